// File: doc/BRIEF.md
# Staggered Replicated-Channel Single-Shot Transmit Sequencer

This block sends one frame on each of several replicated bus channels, one channel after the other. The frame engines themselves are outside the block. For every channel the sequencer raises a transmit-request line and then watches that channel's "transmission has begun" indication. The request is pulled back as soon as the start is seen, or when a short start timeout expires. As a result a frame engine can never retry a frame by itself: each channel gets one attempt only.

Channel 0 is served first. Each following channel is served a fixed stagger of D bit times after the one before it, so the replicated buses carry the same traffic shifted by a known amount. All timing is counted in bit times through a bit-tick input. When the last channel's slot has run out, the block gives a one-cycle done pulse and holds a per-channel failure vector. A start request that arrives while a sequence is running is dropped and recorded in a sticky overrun flag. If the block is built with D ≤ T, or with T = 0, the configuration is unusable: every start then fails all channels at once and raises no request.

Top module: `mirror_tx_seq`

## Requirements
- R1: In the cycle after a start is accepted (start_i high while busy_o is low and the configuration is valid), req_o has bit 0 high and all other bits low.
- R2: The request of channel k rises exactly k·D bit ticks after channel 0's request rises, counting the ticks sampled at each rising clock edge. At most one bit of req_o is high at any time.
- R3: If started_i[c] is high in a cycle where req_o[c] is high, req_o[c] is low in the next cycle, and fail_o[c] stays 0 for that sequence. When the start and the expiry of the timeout fall in the same cycle, the start takes precedence.
- R4: If started_i[c] is not seen while req_o[c] is high, req_o[c] falls at the clock edge that samples the T-th bit tick after the request rose, and fail_o[c] becomes 1 at that same edge.
- R5: started_i[c] has no effect while req_o[c] is low. It does not raise a request and it does not clear a failure.
- R6: busy_o is high from the edge that accepts a start until the edge that samples the D-th bit tick of the last channel's slot. At that edge busy_o falls and done_o goes high for exactly one cycle.
- R7: fail_o is cleared when a start is accepted. After done_o it holds its value until the next accepted start.
- R8: A start_i while busy_o is high is ignored and the sequence continues unchanged. overrun_o becomes 1 at the next edge and stays 1 until reset.
- R9: With D ≤ T or T = 0, a start gives done_o and fail_o all ones at the next edge. busy_o and every bit of req_o stay low.
- R10: After reset, req_o, fail_o, busy_o, done_o and overrun_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_tick | input | 1 | One-cycle pulse per bus bit time |
| start_i | input | 1 | Strobe that begins a sequence |
| started_i | input | NUM_CH | Per-channel indication that transmission has begun |
| req_o | output | NUM_CH | Per-channel transmit request |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse when the sequence ends |
| fail_o | output | NUM_CH | Per-channel failure flags of the last sequence |
| overrun_o | output | 1 | Sticky flag: a start arrived while busy |

## Verification
The case hardest to reach from the ports is a start indication that lands in exactly the cycle whose bit tick would expire the timeout. That cycle only exists when the tick divisor, the responder latency and the request edge line up. The bench drives ticks on every clock in one frame, so that a responder latency of T−1 cycles meets the expiring tick. Spurious start indications on channels that are not requested, and a start issued in the middle of a frame, are mixed into other frames. A second instance built with D equal to T covers the rejected configuration.

// File: rtl/stx_pkg.sv
package stx_pkg;

    typedef enum logic [0:0] {
        PH_IDLE   = 1'b0,
        PH_ACTIVE = 1'b1
    } phase_t;

    typedef struct packed {
        phase_t     phase;
        logic [7:0] ch;
    } seq_t;

    // A usable timing needs a non-zero timeout shorter than the stagger.
    function automatic bit cfg_valid(input int stagger, input int timeout);
        return (timeout >= 1) && (stagger > timeout);
    endfunction

endpackage

// File: rtl/stx_bit_timer.sv
module stx_bit_timer #(
    parameter int D_BITS = 5,
    parameter int T_BITS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic tick,
    output logic t_exp,
    output logic d_exp
);
    localparam int CW = (D_BITS > 1) ? $clog2(D_BITS + 1) : 1;
    localparam logic [CW-1:0] T_LAST = CW'(T_BITS - 1);
    localparam logic [CW-1:0] D_LAST = CW'(D_BITS - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign t_exp = tick && (cnt == T_LAST);
    assign d_exp = tick && (cnt == D_LAST);
endmodule

// File: rtl/stx_chan_slice.sv
module stx_chan_slice (
    input  logic clk,
    input  logic rst,
    input  logic launch,
    input  logic tmo,
    input  logic started,
    input  logic clear_fail,
    input  logic force_fail,
    output logic req,
    output logic fail
);
    logic seen;
    logic expired;

    assign seen    = req && started;
    assign expired = req && !started && tmo;

    always_ff @(posedge clk) begin
        if (rst) begin
            req <= 1'b0;
        end else if (launch) begin
            req <= 1'b1;
        end else if (seen || expired) begin
            req <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fail <= 1'b0;
        end else if (force_fail) begin
            fail <= 1'b1;
        end else if (clear_fail) begin
            fail <= 1'b0;
        end else if (expired) begin
            fail <= 1'b1;
        end
    end
endmodule

// File: rtl/mirror_tx_seq.sv
module mirror_tx_seq #(
    parameter int NUM_CH = 3,
    parameter int D_BITS = 5,
    parameter int T_BITS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_tick,
    input  logic              start_i,
    input  logic [NUM_CH-1:0] started_i,
    output logic [NUM_CH-1:0] req_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [NUM_CH-1:0] fail_o,
    output logic              overrun_o
);
    import stx_pkg::*;

    localparam bit         CFG_OK  = cfg_valid(D_BITS, T_BITS);
    localparam logic [7:0] LAST_CH = 8'(NUM_CH - 1);

    seq_t seq;
    logic accept;
    logic advance;
    logic at_last;
    logic t_exp;
    logic d_exp;
    logic [NUM_CH-1:0] launch;

    assign busy_o  = (seq.phase == PH_ACTIVE);
    assign accept  = start_i && !busy_o;
    assign advance = busy_o && d_exp;
    assign at_last = (seq.ch == LAST_CH);

    stx_bit_timer #(.D_BITS(D_BITS), .T_BITS(T_BITS)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clear (|launch),
        .tick  (bit_tick),
        .t_exp (t_exp),
        .d_exp (d_exp)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic sel;
        assign sel = busy_o && (seq.ch == 8'(c));
        if (c == 0) begin : g_first
            assign launch[c] = accept && CFG_OK;
        end else begin : g_next
            assign launch[c] = advance && !at_last && (seq.ch == 8'(c - 1));
        end
        stx_chan_slice u_slice (
            .clk        (clk),
            .rst        (rst),
            .launch     (launch[c]),
            .tmo        (sel && t_exp),
            .started    (started_i[c]),
            .clear_fail (accept && CFG_OK),
            .force_fail (accept && !CFG_OK),
            .req        (req_o[c]),
            .fail       (fail_o[c])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq       <= '{phase: PH_IDLE, ch: 8'd0};
            done_o    <= 1'b0;
            overrun_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (start_i && busy_o) begin
                overrun_o <= 1'b1;
            end
            if (accept) begin
                if (CFG_OK) begin
                    seq <= '{phase: PH_ACTIVE, ch: 8'd0};
                end else begin
                    done_o <= 1'b1;
                end
            end else if (advance) begin
                if (at_last) begin
                    seq.phase <= PH_IDLE;
                    done_o    <= 1'b1;
                end else begin
                    seq.ch <= seq.ch + 8'd1;
                end
            end
        end
    end
endmodule

// File: rtl/stx_checker.sv
module stx_checker #(
    parameter int NUM_CH = 3,
    parameter int D_BITS = 5,
    parameter int T_BITS = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic [NUM_CH-1:0] started_i,
    input logic [NUM_CH-1:0] req_o,
    input logic              busy_o,
    input logic              done_o,
    input logic [NUM_CH-1:0] fail_o,
    input logic              overrun_o
);
    localparam bit CFG_OK = stx_pkg::cfg_valid(D_BITS, T_BITS);

    a_r2_one_req: assert property (@(posedge clk) disable iff (rst)
        $onehot0(req_o));

    a_r6_req_in_busy: assert property (@(posedge clk) disable iff (rst)
        (|req_o) |-> busy_o);

    a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        overrun_o |=> overrun_o);

    a_r7_fail_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i) |=> $stable(fail_o));

    a_r9_no_req_bad_cfg: assert property (@(posedge clk) disable iff (rst)
        !CFG_OK |-> (req_o == '0));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        a_r3_withdraw: assert property (@(posedge clk) disable iff (rst)
            (req_o[c] && started_i[c]) |=> (!req_o[c] && !fail_o[c]));
    end
endmodule

bind mirror_tx_seq stx_checker #(
    .NUM_CH (NUM_CH),
    .D_BITS (D_BITS),
    .T_BITS (T_BITS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .started_i (started_i),
    .req_o     (req_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .fail_o    (fail_o),
    .overrun_o (overrun_o)
);

// File: tb/mirror_tx_seq_tb.sv
module mirror_tx_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N = 3;
    localparam int D = 5;
    localparam int T = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_tick = 1'b0;
    logic start_i = 1'b0;
    logic [N-1:0] started_i;
    logic [N-1:0] req_o, fail_o;
    logic busy_o, done_o, overrun_o;

    logic bstart = 1'b0;
    logic [N-1:0] breq, bfail;
    logic bbusy, bdone, bovr;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mirror_tx_seq #(.NUM_CH(N), .D_BITS(D), .T_BITS(T)) u_dut (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .start_i(start_i),
        .started_i(started_i), .req_o(req_o), .busy_o(busy_o),
        .done_o(done_o), .fail_o(fail_o), .overrun_o(overrun_o));

    mirror_tx_seq #(.NUM_CH(N), .D_BITS(2), .T_BITS(2)) u_bad (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .start_i(bstart),
        .started_i('0), .req_o(breq), .busy_o(bbusy),
        .done_o(bdone), .fail_o(bfail), .overrun_o(bovr));

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- stimulus helpers (driven at negedge) ----------------
    int tick_div = 1;
    int tick_ph  = 0;
    int lat [N];        // responder latency in cycles, -1 = never answers
    int rcnt[N];
    logic [N-1:0] spur = '0;

    always @(negedge clk) begin
        tick_ph  = (tick_ph + 1) % tick_div;
        bit_tick <= (tick_ph == 0);
        for (int c = 0; c < N; c++) begin
            if (req_o[c]) rcnt[c] = rcnt[c] + 1; else rcnt[c] = 0;
            started_i[c] <= spur[c] || (req_o[c] && lat[c] >= 0 && rcnt[c] == lat[c] + 1);
        end
    end

    // ---------------- behavioural reference ----------------
    bit m_busy, m_done, m_ovr, m_pend;
    int m_ch, m_cnt, tick_total;
    logic [N-1:0] m_req, m_fail;
    int rise_tick[N];
    logic [N-1:0] req_prev;

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_done = 0; m_ovr = 0; m_pend = 0;
            m_ch = 0; m_cnt = 0; m_req = '0; m_fail = '0; tick_total = 0;
        end else begin
            if (bit_tick) tick_total++;
            m_done = 0;
            if (!m_busy) begin
                if (start_i) begin
                    m_busy = 1; m_ch = 0; m_cnt = 0; m_req = 1;
                    m_fail = '0; m_pend = 1;
                end
            end else begin
                if (start_i) m_ovr = 1;
                if (m_pend) begin
                    if (started_i[m_ch]) begin
                        m_req = '0; m_pend = 0;
                    end else if (bit_tick && m_cnt == T - 1) begin
                        m_req = '0; m_pend = 0; m_fail[m_ch] = 1'b1;
                    end
                end
                if (bit_tick) begin
                    if (m_cnt == D - 1) begin
                        if (m_ch == N - 1) begin
                            m_busy = 0; m_done = 1;
                        end else begin
                            m_ch++; m_cnt = 0; m_req = '0; m_req[m_ch] = 1'b1; m_pend = 1;
                        end
                    end else begin
                        m_cnt++;
                    end
                end
            end
        end
        #(CLK_PERIOD/4);
        if (!rst) begin
            check("R2 req_o", int'(req_o), int'(m_req));
            check("R4 fail_o", int'(fail_o), int'(m_fail));
            check("R6 busy_o", int'(busy_o), int'(m_busy));
            check("R6 done_o", int'(done_o), int'(m_done));
            check("R8 overrun_o", int'(overrun_o), int'(m_ovr));
            for (int c = 0; c < N; c++)
                if (req_o[c] && !req_prev[c]) rise_tick[c] = tick_total;
        end
        req_prev = req_o;
    end

    task automatic pulse_start();
        @(negedge clk); start_i <= 1'b1;
        @(negedge clk); start_i <= 1'b0;
    endtask

    task automatic wait_done();
        int guard = 0;
        while (!done_o && guard < 2000) begin
            @(negedge clk); guard++;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 60000);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < N; c++) begin lat[c] = 0; rcnt[c] = 0; end
        started_i = '0;
        req_prev  = '0;
        repeat (3) @(negedge clk);
        rst <= 1'b0;
        @(negedge clk);
        // R10: reset state
        check("R10 req_o", int'(req_o), 0);
        check("R10 fail_o", int'(fail_o), 0);
        check("R10 busy", int'(busy_o), 0);
        check("R10 done", int'(done_o), 0);
        check("R10 overrun", int'(overrun_o), 0);

        // Frame A: every channel answers, tick on every clock
        tick_div = 1;
        @(negedge clk); start_i <= 1'b1;
        @(negedge clk); start_i <= 1'b0;
        check("R1 first request", int'(req_o), 1);
        wait_done();
        check("R3 no failures", int'(fail_o), 0);
        for (int k = 1; k < N; k++)
            check("R2 stagger ticks", rise_tick[k] - rise_tick[0], k * D);

        // Frame B: start meets the expiring tick (latency T-1), ch1 silent
        lat[0] = T - 1; lat[1] = -1; lat[2] = 0;
        pulse_start();
        wait_done();
        check("R3 start beats timeout", int'(fail_o[0]), 0);
        check("R4 silent channel fails", int'(fail_o[1]), 1);
        repeat (4) @(negedge clk);
        check("R7 fail held after done", int'(fail_o), 2);

        // Frame C: slow ticks, spurious starts, ch2 silent, start mid-frame
        tick_div = 3;
        lat[0] = 2; lat[1] = 1; lat[2] = -1;
        pulse_start();
        check("R7 fail cleared at start", int'(fail_o), 0);
        spur = 3'b100;
        @(negedge clk); spur = '0;
        check("R5 spurious no request", int'(req_o[2]), 0);
        repeat (3) @(negedge clk);
        start_i <= 1'b1;
        @(negedge clk); start_i <= 1'b0;
        check("R8 overrun set", int'(overrun_o), 1);
        check("R8 still busy", int'(busy_o), 1);
        wait_done();
        check("R5 spurious no rescue", int'(fail_o), 4);
        @(negedge clk);
        spur = 3'b001;
        @(negedge clk); spur = '0;
        @(negedge clk);
        check("R5 idle start no effect", int'(fail_o), 4);

        // Frame D: all silent, overrun stays sticky
        tick_div = 2;
        for (int c = 0; c < N; c++) lat[c] = -1;
        pulse_start();
        wait_done();
        check("R4 all silent", int'(fail_o), 7);
        check("R8 overrun sticky", int'(overrun_o), 1);

        // R9: rejected configuration
        @(negedge clk); bstart <= 1'b1;
        @(negedge clk); bstart <= 1'b0;
        check("R9 done", int'(bdone), 1);
        check("R9 fail all", int'(bfail), 7);
        check("R9 busy low", int'(bbusy), 0);
        check("R9 no request", int'(breq), 0);
        @(negedge clk);
        check("R9 done single", int'(bdone), 0);

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule